// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable integer N. It does not use a single wide binary counter. A small prescaler alternates between dividing by P and by P+1. A swallow count A and a main count B, both counted in prescaler cycles, decide which modulus the prescaler uses. Over one output period the prescaler runs A cycles at P+1 and B−A cycles at P. The total ratio is therefore N = P·B + A. With the default P = 32, a ratio such as 36200 splits into B = 1131 and A = 8.

Software-facing logic upstream supplies A and B through a load strobe. The block keeps the loaded pair as pending values. The running counters take the pending pair at the next terminal count, so an output period never mixes two ratios. A synchronous counter-reset input sends both counters and the prescaler phase straight back to their load point, using the pending pair. A main count below 3 is prohibited. Such a value is replaced by 3, and a flag shows that the last loaded value was replaced.

The outputs are a one-cycle pulse per output period and the modulus-control level. Every input clock cycle counts as one input cycle of the division.

Top module: `pulse_swallow_div`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block takes A = 0 and B = 3 as both its pending and its running values. `div_pulse`, `mod_ctl` and `clamp_flag` read 0 during reset. The first output period after reset is 96 cycles long.
- R2: `div_pulse` is high for exactly one clock cycle per output period, on the last cycle of the period. A period lasts P·B + A clock cycles, with P = 32.
- R3: `mod_ctl` is 1 while the prescaler divides by P+1 and 0 while it divides by P. In each period it is high for the first A prescaler cycles, which is A·(P+1) clock cycles, and low for the rest of the period.
- R4: The swallow count boundaries are handled. A = 0 gives exactly 32·B cycles with `mod_ctl` never high. A = 31 with B = 31 gives 1023 cycles with `mod_ctl` high throughout.
- R5: A main count of 0, 1 or 2 is replaced by 3, and `clamp_flag` goes to 1 on the cycle after that load. A later load with B ≥ 3 clears `clamp_flag` to 0.
- R6: A pair loaded with `cfg_load` in the middle of a period does not change that period. The new pair first applies to the period that follows the next `div_pulse`.
- R7: `cnt_rst` high at a clock edge restarts the period from the load point using the pending pair, including a pair loaded in the same cycle. The next full period then has the new length.
- R8: With A = 8 and B = 1131, the output period is exactly 36200 clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_rst | input | 1 | Synchronous restart of counters and prescaler phase |
| cfg_load | input | 1 | Strobe that captures `swal_in` and `main_in` as the pending pair |
| swal_in | input | 5 | Swallow count A, from 0 to 31 |
| main_in | input | 13 | Main count B, from 3 to 8191 |
| div_pulse | output | 1 | One-cycle pulse on the last cycle of each output period |
| mod_ctl | output | 1 | Modulus control: 1 selects P+1, 0 selects P |
| clamp_flag | output | 1 | 1 when the last loaded main count was below 3 and was replaced |

## Verification
The period-length and modulus-span assertions assume that every loaded pair satisfies A ≤ B. When A > B, the period ends after B prescaler cycles, all of them at P+1, and the P·B + A relation no longer holds. Every pair the stimulus loads keeps A at or below the effective B, including the clamped case, where A = 2 and B becomes 3. The bench always starts its next stage after a pulse, so that a restart never coincides with a terminal count.

// File: rtl/psd_pkg.sv
// Shared defaults and the modulus-select type for the pulse-swallow divider.
// Assumes nothing beyond standard SystemVerilog packages.
package psd_pkg;
    localparam int PSD_P_LOG2 = 5;   // prescaler low modulus is 2**PSD_P_LOG2
    localparam int PSD_A_W    = 5;   // swallow count width
    localparam int PSD_B_W    = 13;  // main count width
    localparam int PSD_B_MIN  = 3;   // smallest permitted main count

    // Which modulus the prescaler applies in the current prescaler cycle.
    typedef enum logic {
        MOD_LOW  = 1'b0,  // divide by P
        MOD_HIGH = 1'b1   // divide by P+1
    } mod_e;
endpackage

// File: rtl/psd_cfg_latch.sv
// Pending configuration holder.
// Captures the swallow and main counts on cfg_load and replaces a main count
// below B_MIN with B_MIN. Offers the next pending pair combinationally, so a
// reload in the same cycle as a load uses the new pair.
// Assumes cfg_load is synchronous to clk.
module psd_cfg_latch import psd_pkg::*; #(
    parameter int A_W   = PSD_A_W,
    parameter int B_W   = PSD_B_W,
    parameter int B_MIN = PSD_B_MIN
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_load,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    output logic [A_W-1:0] nxt_a,
    output logic [B_W-1:0] nxt_b,
    output logic           clamp_flag
);
    localparam logic [B_W-1:0] B_FLOOR = B_W'(B_MIN);

    logic [A_W-1:0] pend_a;
    logic [B_W-1:0] pend_b;
    logic           b_low;

    // Detect a prohibited main count on the input.
    always_comb b_low = (b_in < B_FLOOR);

    // Next pending pair: the input when loading, else the held pair.
    always_comb begin
        nxt_a = pend_a;
        nxt_b = pend_b;
        if (cfg_load) begin
            nxt_a = a_in;
            nxt_b = b_low ? B_FLOOR : b_in;
        end
    end

    // Hold the pending pair and the clamp report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_a     <= '0;
            pend_b     <= B_FLOOR;
            clamp_flag <= 1'b0;
        end else begin
            pend_a <= nxt_a;
            pend_b <= nxt_b;
            if (cfg_load) begin
                clamp_flag <= b_low;
            end
        end
    end

    // R5
    pend_b_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_b >= B_FLOOR);

    // R5
    clamp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && (b_in < B_FLOOR)) |=> clamp_flag);

    // R5
    clamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(clamp_flag));
endmodule

// File: rtl/psd_prescaler.sv
// Dual-modulus prescaler.
// Counts input cycles and raises pre_tc on the last cycle of each prescaler
// cycle, whose length is P or P+1 as chosen by mod_sel.
// Assumes mod_sel changes only when a prescaler cycle ends or on a restart.
module psd_prescaler import psd_pkg::*; #(
    parameter int P_LOG2 = PSD_P_LOG2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  mod_e mod_sel,
    output logic pre_tc
);
    localparam int              P       = 1 << P_LOG2;
    localparam int              PW      = P_LOG2 + 1;
    localparam logic [PW-1:0]   LAST_LO = PW'(P - 1);
    localparam logic [PW-1:0]   LAST_HI = PW'(P);

    logic [PW-1:0] phase;

    // End of a prescaler cycle for the current modulus.
    always_comb pre_tc = (phase == ((mod_sel == MOD_HIGH) ? LAST_HI : LAST_LO));

    // Advance the phase and wrap it at the end of the cycle or on a restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || pre_tc) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // R3
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= LAST_HI);

    // R3
    low_mod_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_sel == MOD_LOW) |-> (phase <= LAST_LO));
endmodule

// File: rtl/psd_swallow_ctl.sv
// Swallow and main counters.
// Both counters count down in prescaler cycles. The swallow counter holds the
// prescaler at P+1 until it reaches zero. The main counter ends the output
// period and reloads both counters from the pending pair.
// Assumes the pending main count is at least 1 (the config latch guarantees
// at least B_MIN) and that the pending A does not exceed the pending B.
module psd_swallow_ctl import psd_pkg::*; #(
    parameter int A_W   = PSD_A_W,
    parameter int B_W   = PSD_B_W,
    parameter int B_MIN = PSD_B_MIN
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cnt_rst,
    input  logic           pre_tc,
    input  logic [A_W-1:0] nxt_a,
    input  logic [B_W-1:0] nxt_b,
    output mod_e           mod_sel,
    output logic           term
);
    logic [A_W-1:0] a_cnt;
    logic [B_W-1:0] b_cnt;
    logic           reload;

    // Terminal count: last input cycle of the last prescaler cycle.
    always_comb term = pre_tc && (b_cnt == B_W'(1));

    // Reload at a terminal count or on an explicit restart.
    always_comb reload = cnt_rst || term;

    // Stay at the high modulus while swallow cycles remain.
    always_comb mod_sel = (a_cnt != '0) ? MOD_HIGH : MOD_LOW;

    // Count prescaler cycles down and reload both counters at the load point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_cnt <= '0;
            b_cnt <= B_W'(B_MIN);
        end else if (reload) begin
            a_cnt <= nxt_a;
            b_cnt <= nxt_b;
        end else if (pre_tc) begin
            b_cnt <= b_cnt - 1'b1;
            if (a_cnt != '0) begin
                a_cnt <= a_cnt - 1'b1;
            end
        end
    end

    // R2
    b_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_cnt != '0);

    // R3
    mod_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_cnt != '0) |-> $past(reload));

    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(reload) && !$past(pre_tc))
            |-> ($stable(a_cnt) && $stable(b_cnt)));
endmodule

// File: rtl/pulse_swallow_div.sv
// Pulse-swallow feedback divider top.
// Divides clk by N = P*B + A using a P/P+1 prescaler, a swallow counter and
// a main counter. A loaded pair applies at the next terminal count. cnt_rst
// restarts at once from the pending pair.
// Assumes each loaded pair has A <= effective B.
module pulse_swallow_div import psd_pkg::*; #(
    parameter int P_LOG2 = PSD_P_LOG2,
    parameter int A_W    = PSD_A_W,
    parameter int B_W    = PSD_B_W,
    parameter int B_MIN  = PSD_B_MIN
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cnt_rst,
    input  logic           cfg_load,
    input  logic [A_W-1:0] swal_in,
    input  logic [B_W-1:0] main_in,
    output logic           div_pulse,
    output logic           mod_ctl,
    output logic           clamp_flag
);
    localparam int P  = 1 << P_LOG2;
    localparam int NW = P_LOG2 + B_W + 1;

    logic [A_W-1:0] nxt_a;
    logic [B_W-1:0] nxt_b;
    mod_e           mod_sel;
    logic           pre_tc;
    logic           term;

    psd_cfg_latch #(.A_W(A_W), .B_W(B_W), .B_MIN(B_MIN)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .a_in       (swal_in),
        .b_in       (main_in),
        .nxt_a      (nxt_a),
        .nxt_b      (nxt_b),
        .clamp_flag (clamp_flag)
    );

    psd_prescaler #(.P_LOG2(P_LOG2)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cnt_rst),
        .mod_sel (mod_sel),
        .pre_tc  (pre_tc)
    );

    psd_swallow_ctl #(.A_W(A_W), .B_W(B_W), .B_MIN(B_MIN)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_rst (cnt_rst),
        .pre_tc  (pre_tc),
        .nxt_a   (nxt_a),
        .nxt_b   (nxt_b),
        .mod_sel (mod_sel),
        .term    (term)
    );

    // Drive the output pulse and the modulus level.
    always_comb begin
        div_pulse = term;
        mod_ctl   = (mod_sel == MOD_HIGH);
    end

    // Period observer used only by the assertions below.
    logic [A_W-1:0] cur_a;
    logic [B_W-1:0] cur_b;
    logic [NW-1:0]  per_cnt;
    logic [NW-1:0]  hi_cnt;
    logic [NW-1:0]  per_exp;
    logic [NW-1:0]  hi_exp;

    // Expected length and high-modulus span of the running period.
    always_comb begin
        per_exp = (NW'(cur_b) << P_LOG2) + NW'(cur_a) - NW'(1);
        hi_exp  = NW'(cur_a) * NW'(P + 1);
    end

    // Track the running pair and count cycles since the load point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_a   <= '0;
            cur_b   <= B_W'(B_MIN);
            per_cnt <= '0;
            hi_cnt  <= '0;
        end else if (cnt_rst || term) begin
            cur_a   <= nxt_a;
            cur_b   <= nxt_b;
            per_cnt <= '0;
            hi_cnt  <= '0;
        end else begin
            per_cnt <= per_cnt + 1'b1;
            hi_cnt  <= hi_cnt + NW'(mod_ctl);
        end
    end

    // R2
    period_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_pulse && !cnt_rst) |-> (per_cnt == per_exp));

    // R2
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    // R3
    mod_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_pulse && !cnt_rst) |-> ((hi_cnt + NW'(mod_ctl)) == hi_exp));
endmodule

// File: tb/sim_pulse_swallow_div.sv
module sim_pulse_swallow_div;
    localparam int P = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cnt_rst;
    logic        cfg_load;
    logic [4:0]  swal_in;
    logic [12:0] main_in;
    logic        div_pulse;
    logic        mod_ctl;
    logic        clamp_flag;

    always #5 clk = ~clk;

    pulse_swallow_div u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_rst    (cnt_rst),
        .cfg_load   (cfg_load),
        .swal_in    (swal_in),
        .main_in    (main_in),
        .div_pulse  (div_pulse),
        .mod_ctl    (mod_ctl),
        .clamp_flag (clamp_flag)
    );

    typedef struct {
        int    len;
        int    hi;
        string tag;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    bit   finished = 0;
    int   cnt = 0;
    int   hi = 0;

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Push expected periods for a pair: length P*B+A, high span A*(P+1).
    task automatic push(int b, int a, string tag, int times);
        for (int i = 0; i < times; i++) begin
            exp_t e;
            e.len = P * b + a;
            e.hi  = a * (P + 1);
            e.tag = tag;
            q.push_back(e);
        end
    endtask

    // Load a pair and restart in the same cycle.
    task automatic apply(int a, int b);
        @(posedge clk); #2;
        cfg_load = 1'b1;
        cnt_rst  = 1'b1;
        swal_in  = 5'(a);
        main_in  = 13'(b);
        @(posedge clk); #2;
        cfg_load = 1'b0;
        cnt_rst  = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(posedge clk);
    endtask

    // Monitor: measure each period and compare it with the queue head.
    always @(negedge clk) begin
        if (!rst_n || cnt_rst) begin
            cnt = 0;
            hi  = 0;
        end else begin
            cnt++;
            if (mod_ctl) hi++;
            if (div_pulse) begin
                if (q.size() == 0) begin
                    total++;
                    bad++;
                    $display("FAIL R2 unexpected pulse: actual=%0d expected=none", cnt);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk({e.tag, " period"}, cnt, e.len);
                    chk({e.tag, " high-modulus span"}, hi, e.hi);
                end
                cnt = 0;
                hi  = 0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        rst_n    = 1'b0;
        cnt_rst  = 1'b0;
        cfg_load = 1'b0;
        swal_in  = '0;
        main_in  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 div_pulse in reset", int'(div_pulse), 0);
        chk("R1 mod_ctl in reset", int'(mod_ctl), 0);
        chk("R1 clamp_flag in reset", int'(clamp_flag), 0);
        push(3, 0, "R1 R2 default ratio", 2);
        @(posedge clk); #2;
        rst_n = 1'b1;
        drain();

        // R8: worked example 36200 = 32*1131 + 8
        apply(8, 1131);
        push(1131, 8, "R8 ratio 36200", 1);
        drain();

        // R4: no swallow cycles
        apply(0, 7);
        push(7, 0, "R4 swallow zero", 2);
        drain();

        // R4: maximum swallow equal to main count
        apply(31, 31);
        push(31, 31, "R4 swallow max A=B", 2);
        drain();

        // R3: maximum swallow with a larger main count
        apply(31, 40);
        push(40, 31, "R3 modulus span", 1);
        drain();

        // R6: mid-period load applies only after the next pulse
        apply(5, 10);
        push(10, 5, "R6 period before new pair", 1);
        push(4, 2, "R6 period after new pair", 2);
        repeat (100) @(posedge clk); #2;
        cfg_load = 1'b1;
        swal_in  = 5'd2;
        main_in  = 13'd4;
        @(posedge clk); #2;
        cfg_load = 1'b0;
        drain();

        // R5: prohibited main count replaced by 3
        apply(2, 1);
        push(3, 2, "R5 clamped ratio", 1);
        @(negedge clk);
        chk("R5 clamp_flag after B=1", int'(clamp_flag), 1);
        drain();
        apply(2, 9);
        push(9, 2, "R5 valid ratio", 1);
        @(negedge clk);
        chk("R5 clamp_flag after B=9", int'(clamp_flag), 0);
        drain();

        // R7: restart in mid-period returns to the load point
        apply(3, 6);
        @(negedge clk);
        chk("R7 mod_ctl at load point", int'(mod_ctl), 1);
        chk("R7 div_pulse at load point", int'(div_pulse), 0);
        repeat (50) @(posedge clk); #2;
        cnt_rst = 1'b1;
        @(posedge clk); #2;
        cnt_rst = 1'b0;
        push(6, 3, "R7 period after restart", 1);
        drain();

        finish_run();
    end
endmodule